// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. It drives two controls of an external analog front end: a select line that connects the integrator either to the unknown input or to a reference of opposite polarity, and a clear line that holds the integrator at zero. A single counter serves both phases of the conversion. The first phase integrates the input for a fixed number of clocks. The second phase integrates the reference and counts clocks for as long as the external zero-crossing comparator stays high.

A conversion starts from idle, where the integrator is held cleared and the counter is zero. A start request selects the input for exactly 2^N clocks. The counter then restarts from zero with the reference selected, and counts each clock on which the comparator is still high. The first low comparator sample stops the count. The stopped count is latched as the result and is proportional to the input voltage. A run-down that reaches full scale with the comparator still high is reported as an overflow, and the result saturates.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, intReset is 1, and selRef, done, overflow and result are all 0.
- R2: intReset is 1 in every cycle the sequencer is idle and 0 in every other cycle.
- R3: A start sampled high while idle begins run-up on the next cycle. During run-up selRef is 0 and intReset is 0, and run-up lasts exactly 2^N cycles.
- R4: Right after run-up, selRef is 1 and stays 1 until the conversion ends. It is 0 during idle, run-up and the done cycle.
- R5: During run-down, the count rises by one on each clock on which compIn is sampled high. The first clock that samples compIn low latches the count into result, with overflow cleared to 0.
- R6: If compIn is still sampled high when the run-down count already equals 2^N-1, result becomes all ones and overflow becomes 1.
- R7: done is 1 for exactly one cycle, the cycle after the latching clock, and the sequencer is idle on the following cycle. result and overflow keep their values until the next latch.
- R8: start has no effect outside the idle state. A start held high through a whole conversion does not skip the idle cycle that follows done.
- R9: With an ideal integrator that adds vin per run-up clock and subtracts vref per run-down clock, and a comparator that is high while the integrator is above zero, result equals min(ceil(vin*2^N/vref), 2^N-1). overflow is 1 exactly when that ceiling exceeds 2^N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, sampled in idle only |
| compIn | input | 1 | Zero-crossing comparator, high while integrator is above zero |
| selRef | output | 1 | 1 selects the reference, 0 selects the input |
| intReset | output | 1 | Holds the integrator cleared while high |
| result | output | N | Latched run-down count |
| done | output | 1 | One-cycle pulse when result is valid |
| overflow | output | 1 | Run-down passed full scale; result saturated |

## Verification
The assertions assume that start and compIn are synchronous to clk and settled before each rising edge. They also assume that compIn falls at most once per run-down, as a real integrator ramp crossing zero makes it do. The bench drives start on falling edges. It derives compIn from a numeric integrator that is updated on the rising edge from the selRef and intReset values the block drives. Because that integrator ramps down monotonically during run-down, the comparator never rises again after it falls, and the stimulus stays within these assumptions.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_RUNUP   = 2'd1,
    S_RUNDOWN = 2'd2,
    S_DONE    = 2'd3
  } seqState_t;

  // Strobes from the sequencer to the counting datapath
  typedef struct packed {
    logic cntClear;   // force counter to zero
    logic cntInc;     // advance counter by one
    logic latchCnt;   // copy counter into result, clear overflow
    logic latchSat;   // load full scale into result, set overflow
  } dpStrobe_t;

endpackage

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       compIn,
  input  logic       cntFull,
  output dpStrobe_t  strb,
  output logic       selRef,
  output logic       intReset,
  output logic       done
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      S_IDLE: begin
        strb.cntClear = 1'b1;
        if (start) stateNext = S_RUNUP;
      end
      S_RUNUP: begin
        if (cntFull) begin
          strb.cntClear = 1'b1;
          stateNext     = S_RUNDOWN;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      S_RUNDOWN: begin
        if (!compIn) begin
          strb.latchCnt = 1'b1;
          stateNext     = S_DONE;
        end else if (cntFull) begin
          strb.latchSat = 1'b1;
          stateNext     = S_DONE;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign intReset = (state == S_IDLE);
  assign selRef   = (state == S_RUNDOWN);
  assign done     = (state == S_DONE);

  // R7: done lasts one cycle and is followed by idle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && intReset));

  // R3: run-up is not left before the counter reports full
  assert_runup_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUNUP && !cntFull) |=> (state == S_RUNUP));

  // R3: leaving idle always selects the input first
  assert_runup_input_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intReset) |-> !selRef);

  // R5: run-down continues while comparator high and count not full
  assert_rundown_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (selRef && compIn && !cntFull) |=> selRef);

  // R8: start during done does not skip idle
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> intReset);

endmodule

// File: rtl/dsadc_datapath.sv
module dsadc_datapath
  import dsadc_pkg::*;
#(
  parameter int N = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  output logic          cntFull,
  output logic [N-1:0]  result,
  output logic          overflow
);

  localparam logic [N-1:0] FULL_SCALE = {N{1'b1}};

  logic [N-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.cntClear) cnt <= '0;
    else if (strb.cntInc)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      overflow <= 1'b0;
    end else if (strb.latchSat) begin
      result   <= FULL_SCALE;
      overflow <= 1'b1;
    end else if (strb.latchCnt) begin
      result   <= cnt;
      overflow <= 1'b0;
    end
  end

  assign cntFull = (cnt == FULL_SCALE);

  // R6: an overflowed result is always full scale
  assert_ovf_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (result == FULL_SCALE));

  // R5: a normal latch captures the count of the previous cycle
  assert_latch_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchCnt |=> (result == $past(cnt) && !overflow));

  // R7: result holds when no latch strobe is present
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.latchCnt || strb.latchSat) |=> $stable(result));

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int N = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          compIn,
  output logic          selRef,
  output logic          intReset,
  output logic [N-1:0]  result,
  output logic          done,
  output logic          overflow
);

  dpStrobe_t strb;
  logic      cntFull;

  dsadc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .compIn   (compIn),
    .cntFull  (cntFull),
    .strb     (strb),
    .selRef   (selRef),
    .intReset (intReset),
    .done     (done)
  );

  dsadc_datapath #(.N(N)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cntFull  (cntFull),
    .result   (result),
    .overflow (overflow)
  );

endmodule

// File: tb/dsadc_seq_bench.sv
module dsadc_seq_bench;

  localparam int N     = 10;
  localparam int SPAN  = 1 << N;
  localparam int MAXC  = SPAN - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         compIn;
  logic         selRef, intReset, done, overflow;
  logic [N-1:0] result;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int printed = 0;

  // Numeric integrator model
  longint aVin = 0;
  longint aVref = 1;
  longint integ = 0;

  always #10 clk = ~clk;

  dsadc_seq #(.N(N)) u_dsadc_seq (
    .clk(clk), .rstN(rstN), .start(start), .compIn(compIn),
    .selRef(selRef), .intReset(intReset), .result(result),
    .done(done), .overflow(overflow)
  );

  always @(posedge clk) begin
    if (!rstN || intReset) integ <= 0;
    else if (!selRef)      integ <= integ + aVin;
    else                   integ <= integ - aVref;
  end
  assign compIn = (integ > 0);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      if (printed < 20) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      printed++;
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 integrate input, 2 integrate reference, 3 report
  int     mPhase = 0;
  int     mElapsed = 0;
  int     mHigh = 0;
  longint mRes = 0;
  bit     mOvf = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mElapsed = 0; mHigh = 0; mRes = 0; mOvf = 0;
    end else begin
      case (mPhase)
        0: if (start) begin mPhase = 1; mElapsed = 0; end
        1: begin
          mElapsed++;
          if (mElapsed == SPAN) begin mPhase = 2; mHigh = 0; end
        end
        2: begin
          if (!compIn) begin mRes = mHigh; mOvf = 0; mPhase = 3; end
          else if (mHigh == MAXC) begin mRes = MAXC; mOvf = 1; mPhase = 3; end
          else mHigh++;
        end
        default: mPhase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(intReset == (mPhase == 0), "R2 intReset vs model", intReset, mPhase == 0);
      chk(selRef == (mPhase == 2), "R4 selRef vs model", selRef, mPhase == 2);
      chk(done == (mPhase == 3), "R7 done vs model", done, mPhase == 3);
      chk(result == mRes, "R5 result vs model", result, mRes);
      chk(overflow == mOvf, "R6 overflow vs model", overflow, mOvf);
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog R9", cycles, 150000);
      finishRun();
    end
  end

  task automatic doConv(input longint vin, input longint vref, input bit holdStart, input bit pokeStart);
    int     upLen = 0;
    longint m;
    longint expRes;
    bit     expOvf;
    aVin = vin; aVref = vref;
    m = (vin * SPAN + vref - 1) / vref;
    expOvf = (m > MAXC);
    expRes = expOvf ? MAXC : m;
    start = 1'b1;
    @(negedge clk);
    if (!holdStart) start = 1'b0;
    while (!selRef && !done) begin
      if (!intReset) upLen++;
      if (pokeStart && upLen == 7) start = 1'b1;  // R8: ignored mid run-up
      if (pokeStart && upLen == 9) start = 1'b0;
      @(negedge clk);
    end
    chk(upLen == SPAN, "R3 run-up length", upLen, SPAN);
    while (!done) @(negedge clk);
    chk(result == expRes, "R9 result vs ideal ramps", result, expRes);
    chk(overflow == expOvf, "R9 overflow vs ideal ramps", overflow, expOvf);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", done, 0);
    chk(intReset == 1'b1, "R8 idle follows done", intReset, 1);
    chk(result == expRes, "R7 result held", result, expRes);
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    chk(intReset == 1'b1, "R1 reset intReset", intReset, 1);
    chk(selRef == 1'b0, "R1 reset selRef", selRef, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(overflow == 1'b0, "R1 reset overflow", overflow, 0);
    chk(result == 0, "R1 reset result", result, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(intReset == 1'b1 && result == 0, "R1 after reset idle", intReset, 1);
    doConv(0, 1024, 0, 0);       // immediate zero crossing
    doConv(1, 1024, 0, 0);
    doConv(300, 1024, 0, 1);     // start pulsed during run-up
    doConv(1023, 1024, 0, 0);    // full scale exact, R6 not set
    doConv(1024, 1024, 0, 0);    // one past full scale, R6 overflow
    doConv(2000, 1024, 1, 0);    // far overflow, start held through
    doConv(500, 1000, 0, 0);     // overflow cleared again
    doConv(333, 700, 0, 0);
    doConv(999, 1000, 0, 0);
    repeat (5) @(negedge clk);
    chk(intReset == 1'b1 && done == 1'b0, "R2 stays idle without start", intReset, 1);
    finishRun();
  end

endmodule